// File: doc/BRIEF.md
# Parallel ADC Read Sequencer

This block sits on the host side of a 14-bit successive-approximation converter with a parallel output bus. It drives the converter's chip-select and read/convert lines. On each sample request it walks through three chip-select falling edges. The first starts acquisition. The second starts the conversion and tells the converter whether to keep its reference powered afterwards (standby) or to power it down (shutdown). The third, issued once the converter has signalled end-of-conversion, reads the result. The block then returns the 14-bit word with a one-cycle valid strobe.

Every interval on the pins comes from a nanosecond parameter. Each is converted to system clock cycles through a parameterized clock frequency, rounding up to a minimum of one cycle. These intervals are: setup and hold of read/convert around a chip-select fall, the chip-select pulse widths, the acquisition window, the data access time, the bus relinquish time and the end-of-conversion timeout. The block remembers whether the previous conversion asked for shutdown. When it did, the acquisition window is stretched to the much longer reference wake-up time. A range-type input, sampled with the request, selects straight binary or offset binary. For offset binary the result is turned into two's complement.

Top module: `adc_seq_reader`

## Requirements
- R1: While reset is asserted and afterwards until the first request, adcCsN is 1, adcRdConv is 0, and resultValid and timeoutErr are 0.
- R2: A sampleReq pulse while idle produces an acquire edge, which is a fall of adcCsN with adcRdConv at 0. Around every adcCsN fall, adcRdConv is stable for at least EDGE_NS before and after it. Every high and low pulse of adcCsN lasts at least EDGE_NS.
- R3: The convert edge is the second adcCsN fall and comes at least ACQ_NS after the acquire edge. On it, adcRdConv equals the shutdownAfter value sampled with the request (1 = shutdown, 0 = standby).
- R4: When the previous conversion selected shutdown, the convert edge comes at least WAKE_NS after the acquire edge. The first conversion after reset counts as following a shutdown. After a standby conversion the window is the short one, below WAKE_NS.
- R5: The read edge is the third adcCsN fall. It has adcRdConv at 1 and is issued only after adcEocN (active low) has been seen low. adcData is captured no sooner than DATA_NS after the read edge.
- R6: The captured word appears on result together with a one-cycle resultValid pulse. With bipolar = 0 at request time, result equals adcData. With bipolar = 1, bit 13 is inverted and bits 12..0 pass through.
- R7: If adcEocN has not fallen within TMO_NS of the convert edge, timeoutErr pulses for one cycle. No read edge and no resultValid follow, adcCsN stays high, and the next request is served normally.
- R8: sampleReq, shutdownAfter and bipolar are ignored while a sequence is in progress. Each accepted request produces exactly three adcCsN falls and one resultValid, or one timeoutErr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleReq | input | 1 | Start one acquire/convert/read sequence (accepted when idle) |
| shutdownAfter | input | 1 | 1: converter powers its reference down after this conversion; 0: standby |
| bipolar | input | 1 | 1: converter outputs offset binary, return two's complement |
| adcCsN | output | 1 | Converter chip select, active low |
| adcRdConv | output | 1 | Converter read/convert select |
| adcEocN | input | 1 | Converter end-of-conversion, falls when done |
| adcData | input | 14 | Converter parallel data bus |
| result | output | 14 | Last captured conversion word |
| resultValid | output | 1 | One-cycle strobe: result is new |
| timeoutErr | output | 1 | One-cycle strobe: end-of-conversion never arrived |

## Verification
The bench builds the block at 100 MHz with the default edge, acquisition, access and relinquish times. It lowers WAKE_NS to 5000 and TMO_NS to 8000, so that many shutdown-to-wake transitions and a real timeout fit in a short run. A converter model times every pin edge in nanoseconds. It sweeps walking-one and corner data codes across both range types and both power modes. Its end-of-conversion delays run from zero up to just under the timeout, and one conversion never ends.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ_LOW,
    ST_ACQ_WAIT,
    ST_CNV_LOW,
    ST_WAIT_EOC,
    ST_RD_LOW,
    ST_RELEASE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch request options
    logic setPrev;    // remember power mode of this conversion
    logic latchData;  // capture the bus
    logic flagTmo;    // end-of-conversion timeout
  } seqStrobe_t;

  function automatic int unsigned nsToCyc(input longint unsigned ns,
                                          input longint unsigned hz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = ns * hz;
    cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
    if (cyc == 64'd0) cyc = 64'd1;
    return cyc[31:0];
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_dpath.sv
`timescale 1ns/1ps
module adc_rd_dpath
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              shutdownAfter,
  input  logic              bipolar,
  input  logic              adcEocN,
  input  logic [DATA_W-1:0] adcData,
  output logic              modeShdn,
  output logic              prevShdn,
  output logic              eocLow,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              timeoutErr
);

  logic              bipQ;
  logic [1:0]        eocSync;
  logic [DATA_W-1:0] wordConv;

  // offset binary to two's complement: flip the sign bit
  always_comb begin
    wordConv = adcData;
    if (bipQ) wordConv[DATA_W-1] = ~adcData[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeShdn    <= 1'b0;
      bipQ        <= 1'b0;
      prevShdn    <= 1'b1;   // reference state unknown after reset
      eocSync     <= 2'b11;
      result      <= '0;
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      eocSync     <= {eocSync[0], adcEocN};
      resultValid <= strb.latchData;
      timeoutErr  <= strb.flagTmo;
      if (strb.capReq) begin
        modeShdn <= shutdownAfter;
        bipQ     <= bipolar;
      end
      if (strb.setPrev)   prevShdn <= modeShdn;
      if (strb.latchData) result   <= wordConv;
    end
  end

  assign eocLow = ~eocSync[1];

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R7
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !resultValid);

endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned EDGE_CYC  = 8,
  parameter int unsigned ACQ_REST  = 192,
  parameter int unsigned WAKE_REST = 192,
  parameter int unsigned RD_CYC    = 8,
  parameter int unsigned REL_CYC   = 8,
  parameter int unsigned TMO_REST  = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleReq,
  input  logic       modeShdn,
  input  logic       prevShdn,
  input  logic       eocLow,
  output logic       adcCsN,
  output logic       adcRdConv,
  output seqStrobe_t strb
);

  localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(EDGE_CYC - 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_REST - 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_REST - 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(REL_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(TMO_REST - 1);

  seqState_t        state, nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] acqLast;

  function automatic logic rdOf(input seqState_t s, input logic m);
    case (s)
      ST_ACQ_WAIT, ST_CNV_LOW: return m;
      ST_WAIT_EOC, ST_RD_LOW:  return 1'b1;
      default:                 return 1'b0;
    endcase
  endfunction

  function automatic logic csLow(input seqState_t s);
    return (s == ST_ACQ_LOW) || (s == ST_CNV_LOW) || (s == ST_RD_LOW);
  endfunction

  always_comb begin
    nxt     = state;
    strb    = '0;
    acqLast = prevShdn ? WAKE_LAST : ACQ_LAST;
    case (state)
      ST_IDLE: begin
        strb.capReq = sampleReq;
        if (sampleReq) nxt = ST_ACQ_LOW;
      end
      ST_ACQ_LOW:  if (cnt == EDGE_LAST) nxt = ST_ACQ_WAIT;
      ST_ACQ_WAIT: if (cnt == acqLast) nxt = ST_CNV_LOW;
      ST_CNV_LOW: begin
        strb.setPrev = 1'b1;
        if (cnt == EDGE_LAST) nxt = ST_WAIT_EOC;
      end
      ST_WAIT_EOC: begin
        if (eocLow && cnt >= EDGE_LAST) begin
          nxt = ST_RD_LOW;
        end else if (cnt >= TMO_LAST) begin
          strb.flagTmo = 1'b1;
          nxt = ST_RELEASE;
        end
      end
      ST_RD_LOW: begin
        if (cnt == RD_LAST) begin
          strb.latchData = 1'b1;
          nxt = ST_RELEASE;
        end
      end
      ST_RELEASE:  if (cnt == REL_LAST) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      adcCsN    <= 1'b1;
      adcRdConv <= 1'b0;
    end else begin
      state     <= nxt;
      cnt       <= (nxt != state || nxt == ST_IDLE) ? '0 : cnt + 1'b1;
      adcCsN    <= ~csLow(nxt);
      adcRdConv <= rdOf(nxt, modeShdn);
    end
  end

  // R2
  acq_rd_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(adcCsN) && state == ST_ACQ_LOW) |-> !adcRdConv);

  // R2
  fall_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |-> $stable(adcRdConv));

  // R2
  fall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(adcCsN) |=> $stable(adcRdConv));

  // R3
  cnv_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(adcCsN) && state == ST_CNV_LOW) |-> (adcRdConv == modeShdn));

  // R5
  read_after_eoc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(adcCsN) && state == ST_RD_LOW) |-> $past(eocLow));

endmodule

// File: rtl/adc_seq_reader.sv
`timescale 1ns/1ps
module adc_seq_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned DATA_W    = 14,
  parameter int unsigned EDGE_NS   = 80,
  parameter int unsigned ACQ_NS    = 2000,
  parameter int unsigned WAKE_NS   = 12_000_000,
  parameter int unsigned DATA_NS   = 80,
  parameter int unsigned RELINQ_NS = 80,
  parameter int unsigned TMO_NS    = 20_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleReq,
  input  logic              shutdownAfter,
  input  logic              bipolar,
  output logic              adcCsN,
  output logic              adcRdConv,
  input  logic              adcEocN,
  input  logic [DATA_W-1:0] adcData,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              timeoutErr
);

  localparam int unsigned EDGE_CYC  = nsToCyc(EDGE_NS, CLK_HZ);
  localparam int unsigned ACQ_CYC   = nsToCyc(ACQ_NS, CLK_HZ);
  localparam int unsigned WAKE_CYC  = nsToCyc(WAKE_NS, CLK_HZ);
  localparam int unsigned TMO_CYC   = nsToCyc(TMO_NS, CLK_HZ);
  localparam int unsigned ACQ_REST  = maxU(ACQ_CYC, 2 * EDGE_CYC) - EDGE_CYC;
  localparam int unsigned WAKE_REST = maxU(maxU(WAKE_CYC, ACQ_CYC), 2 * EDGE_CYC) - EDGE_CYC;
  localparam int unsigned TMO_REST  = maxU(TMO_CYC, 2 * EDGE_CYC + 1) - EDGE_CYC;
  localparam int unsigned RD_CYC    = maxU(nsToCyc(DATA_NS, CLK_HZ), EDGE_CYC);
  localparam int unsigned REL_CYC   = maxU(nsToCyc(RELINQ_NS, CLK_HZ), EDGE_CYC);
  localparam int unsigned MAX_CYC   = maxU(maxU(WAKE_REST, TMO_REST), maxU(RD_CYC, REL_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  seqStrobe_t strb;
  logic       modeShdn;
  logic       prevShdn;
  logic       eocLow;

  adc_rd_ctrl #(
    .CNT_W    (CNT_W),
    .EDGE_CYC (EDGE_CYC),
    .ACQ_REST (ACQ_REST),
    .WAKE_REST(WAKE_REST),
    .RD_CYC   (RD_CYC),
    .REL_CYC  (REL_CYC),
    .TMO_REST (TMO_REST)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sampleReq(sampleReq),
    .modeShdn (modeShdn),
    .prevShdn (prevShdn),
    .eocLow   (eocLow),
    .adcCsN   (adcCsN),
    .adcRdConv(adcRdConv),
    .strb     (strb)
  );

  adc_rd_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .shutdownAfter(shutdownAfter),
    .bipolar      (bipolar),
    .adcEocN      (adcEocN),
    .adcData      (adcData),
    .modeShdn     (modeShdn),
    .prevShdn     (prevShdn),
    .eocLow       (eocLow),
    .result       (result),
    .resultValid  (resultValid),
    .timeoutErr   (timeoutErr)
  );

endmodule

// File: tb/adc_seq_reader_tb.sv
`timescale 1ns/1ps
module adc_seq_reader_tb;

  localparam int EDGE   = 80;
  localparam int ACQ    = 2000;
  localparam int WAKE   = 5000;
  localparam int TMO    = 8000;
  localparam int RELINQ = 80;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleReq, shutdownAfter, bipolar;
  logic        adcCsN, adcRdConv, adcEocN;
  logic [13:0] adcData, result;
  logic        resultValid, timeoutErr;

  int nTests = 0, nFail = 0;
  bit prevB = 1'b1;

  always #5 clk = ~clk;

  adc_seq_reader #(
    .CLK_HZ(100_000_000), .DATA_W(14), .EDGE_NS(EDGE), .ACQ_NS(ACQ),
    .WAKE_NS(WAKE), .DATA_NS(80), .RELINQ_NS(RELINQ), .TMO_NS(TMO)
  ) u_dut (
    .clk(clk), .rstN(rstN), .sampleReq(sampleReq), .shutdownAfter(shutdownAfter),
    .bipolar(bipolar), .adcCsN(adcCsN), .adcRdConv(adcRdConv), .adcEocN(adcEocN),
    .adcData(adcData), .result(result), .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  // pin timing monitor (R2)
  logic   pCs = 1'b1, pRd = 1'b0;
  longint tFall = -100000, tRise = -100000, tRd = -100000, nowT;
  int     monChk = 0, monFail = 0, csFalls = 0;

  always @(adcCsN or adcRdConv) begin
    nowT = longint'($time);
    if (rstN === 1'b1) begin
      if (pCs === 1'b1 && adcCsN === 1'b0) begin
        monChk += 2;
        if (nowT - tRd < EDGE) begin
          monFail++;
          $display("FAIL R2 setup: actual %0d ns expected >= %0d", nowT - tRd, EDGE);
        end
        if (nowT - tRise < EDGE) begin
          monFail++;
          $display("FAIL R2 cs high width: actual %0d ns expected >= %0d", nowT - tRise, EDGE);
        end
        csFalls++;
        tFall = nowT;
      end else if (pCs === 1'b0 && adcCsN === 1'b1) begin
        monChk++;
        if (nowT - tFall < EDGE) begin
          monFail++;
          $display("FAIL R2 cs low width: actual %0d ns expected >= %0d", nowT - tFall, EDGE);
        end
        tRise = nowT;
      end
      if (adcRdConv !== pRd) begin
        monChk++;
        if (nowT - tFall < EDGE) begin
          monFail++;
          $display("FAIL R2 hold: actual %0d ns expected >= %0d", nowT - tFall, EDGE);
        end
        tRd = nowT;
      end
    end
    pCs = adcCsN;
    pRd = adcRdConv;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [13:0] codeAt(input int i);
    if (i < 14) return 14'(1 << i);
    case (i - 14)
      0: return 14'h0000;
      1: return 14'h3FFF;
      2: return 14'h1FFF;
      3: return 14'h2000;
      4: return 14'h2AAA;
      default: return 14'h1555;
    endcase
  endfunction

  task automatic runConv(input bit mode, input bit bip, input logic [13:0] code,
                         input int delayNs, input bit never, input bit extra);
    longint tA, tC, tE, tR;
    int fallsRef;
    bit got, sawV;
    logic [13:0] expW;
    expW = bip ? {~code[13], code[12:0]} : code;
    @(negedge clk);
    shutdownAfter = mode; bipolar = bip; sampleReq = 1'b1;
    @(negedge adcCsN);
    tA = longint'($time);
    #1;
    chk(adcRdConv == 1'b0, "R2 acquire rdConv", adcRdConv, 0);
    chk(tA - tRise >= RELINQ, "R5 relinquish", tA - tRise, RELINQ);
    if (extra) begin
      shutdownAfter = ~mode; bipolar = ~bip;     // R8: must be ignored
      repeat (3) @(negedge clk);
    end
    sampleReq = 1'b0; shutdownAfter = mode; bipolar = bip;
    @(negedge adcCsN);
    tC = longint'($time);
    #1;
    chk(adcRdConv == mode, "R3 convert mode", adcRdConv, mode);
    chk(tC - tA >= ACQ, "R3 acquisition window", tC - tA, ACQ);
    if (prevB) chk(tC - tA >= WAKE, "R4 wake window", tC - tA, WAKE);
    else       chk(tC - tA < WAKE, "R4 short window after standby", tC - tA, ACQ);
    prevB = mode;
    if (!never) begin
      #(delayNs - 1);
      adcEocN = 1'b0;
      tE = longint'($time);
      @(negedge adcCsN);
      tR = longint'($time);
      #1;
      chk(adcRdConv == 1'b1, "R5 read rdConv", adcRdConv, 1);
      chk(tR >= tE, "R5 read after eoc", tR, tE);
      #39;
      adcData = code;
      got = 1'b0;
      for (int c = 0; c < 100 && !got; c++) begin
        @(negedge clk);
        if (resultValid) got = 1'b1;
      end
      chk(got, "R6 resultValid", got, 1);
      chk(result == expW, "R6 result word", result, expW);
      @(negedge clk);
      chk(!resultValid, "R6 single pulse", resultValid, 0);
      adcEocN = 1'b1; adcData = ~code;
      if (extra) begin
        fallsRef = csFalls; sawV = 1'b0;
        repeat (60) begin
          @(negedge clk);
          if (resultValid) sawV = 1'b1;
        end
        chk(csFalls == fallsRef, "R8 no extra cs edge", csFalls - fallsRef, 0);
        chk(!sawV, "R8 no extra result", sawV, 0);
      end
    end else begin
      fallsRef = csFalls; got = 1'b0; sawV = 1'b0;
      for (int c = 0; c < 3000 && !got; c++) begin
        @(negedge clk);
        if (resultValid) sawV = 1'b1;
        if (timeoutErr) got = 1'b1;
      end
      chk(got, "R7 timeout flagged", got, 1);
      chk(longint'($time) - tC >= TMO, "R7 timeout delay", longint'($time) - tC, TMO);
      @(negedge clk);
      chk(!timeoutErr, "R7 single pulse", timeoutErr, 0);
      repeat (20) @(negedge clk);
      chk(csFalls == fallsRef, "R7 no read edge", csFalls - fallsRef, 0);
      chk(!sawV, "R7 no result", sawV, 0);
      chk(adcCsN == 1'b1, "R7 cs idle high", adcCsN, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests + monChk + 1, nFail + monFail + 1);
    $finish;
  end

  initial begin
    rstN = 1'b0; sampleReq = 1'b0; shutdownAfter = 1'b0; bipolar = 1'b0;
    adcEocN = 1'b1; adcData = 14'h0;
    repeat (5) @(negedge clk);
    chk(adcCsN == 1'b1, "R1 reset csN", adcCsN, 1);
    chk(adcRdConv == 1'b0, "R1 reset rdConv", adcRdConv, 0);
    chk(resultValid == 1'b0, "R1 reset valid", resultValid, 0);
    chk(timeoutErr == 1'b0, "R1 reset timeout", timeoutErr, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk(adcCsN == 1'b1 && csFalls == 0, "R1 idle csN", adcCsN, 1);
    chk(adcRdConv == 1'b0, "R1 idle rdConv", adcRdConv, 0);

    // sweep codes x range type x power mode x eoc delay
    for (int k = 0; k < 40; k++) begin
      runConv((k % 3) == 0, k[0] ^ (k >= 20), codeAt(k % 20), 1 + (k % 6) * 1300, 1'b0, 1'b0);
    end
    runConv(1'b0, 1'b1, 14'h2001, 7000, 1'b0, 1'b0);   // just under timeout
    runConv(1'b0, 1'b0, 14'h0ABC, 0, 1'b1, 1'b0);      // R7 never ends
    runConv(1'b0, 1'b1, 14'h3210, 500, 1'b0, 1'b0);    // recovery after timeout
    runConv(1'b1, 1'b1, 14'h1234, 800, 1'b0, 1'b1);    // R8 extra request
    runConv(1'b0, 1'b0, 14'h2222, 800, 1'b0, 1'b0);    // wake window after shutdown

    repeat (10) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nTests + monChk, nFail + monFail);
    $finish;
  end

endmodule